// File: doc/BRIEF.md
# Bus Address Map Translator

This block converts 18-bit addresses issued by DMA masters on an I/O bus into 22-bit physical memory addresses. The bus address space is cut into 32 pages of 8 KB. Each page has a 22-bit base held in a small register file, and the in-page offset is added to that base. The topmost bus page never goes through the file. It always lands on a fixed I/O page base, octal 17760000, plus the offset. When the map-enable input is low, the bus address is passed through unchanged, zero-extended to 22 bits.

Software reaches the map entries through a 16-bit register port. Every entry takes four bytes of register space. The even half holds entry bits 15:0, and bit 0 always reads as zero. The odd half holds entry bits 21:16 in its low six bits. Both 16-bit and 8-bit writes are accepted.

The translate result is registered. It comes with a nonexistent-memory flag, raised when the physical address is not below the memory-size input.

Top module: `bus_map_xlate`

## Requirements
- R1: Synchronous reset clears every map entry to zero and drives `reg_rdata`, `xl_paddr` and `xl_nxm` to zero.
- R2: A word write with `reg_addr[1]`=0 stores `reg_wdata[15:1]` in entry bits 15:1 of entry `reg_addr[6:2]`, and forces bit 0 to zero. A read with `reg_addr[1]`=0 returns entry bits 15:0.
- R3: A word write with `reg_addr[1]`=1 stores `reg_wdata[5:0]` in entry bits 21:16 and drops the rest. A read with `reg_addr[1]`=1 returns entry bits 21:16 in `reg_rdata[5:0]`, with zeros above them.
- R4: A byte write (`reg_byte`=1) changes only the lane that `reg_addr[1:0]` selects. Lane 0 is bits 7:0 with bit 0 kept at zero. Lane 1 is bits 15:8. Lane 2 is bits 21:16, taken from data bits 5:0. A lane 3 write leaves the entry unchanged.
- R5: `reg_rdata` shows the half addressed on the previous clock edge, so reads have one cycle of latency.
- R6: With `map_en`=1 and a page number `xl_addr[17:13]` below 31, `xl_paddr` one cycle later equals the page's entry plus `xl_addr[12:0]`, taken modulo 2^22.
- R7: With `map_en`=1 and page number 31, `xl_paddr` equals octal 17760000 plus the offset, whatever entry 31 holds.
- R8: With `map_en`=0, `xl_paddr` equals `xl_addr` zero-extended to 22 bits, one cycle later.
- R9: `xl_nxm` is 1 exactly when the `xl_paddr` produced in the same cycle is greater than or equal to the `mem_size` sampled with the address.
- R10: When an entry is written in the same cycle that a translation reads it, the translation uses the entry's old value. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_byte | input | 1 | Write is 8-bit (1) or 16-bit (0) |
| reg_addr | input | 7 | Register byte address: entry in 6:2, half/lane in 1:0 |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| xl_addr | input | 18 | Bus address to translate |
| map_en | input | 1 | Enable page mapping |
| mem_size | input | 22 | Installed memory size in bytes |
| xl_paddr | output | 22 | Registered physical address |
| xl_nxm | output | 1 | Registered nonexistent-memory flag |

## Verification
A register write and a translation can hit the same entry in the same clock cycle. To provoke this, the bench presents a word write to entry 5 while `xl_addr` points into page 5. It expects the registered address formed from the entry's previous value first. With the same address held, it then expects the new value one cycle later. The bench keeps a model of the entries built from the written data. Every page, several boundary offsets, the carry out of bit 21, and memory sizes on either side of the result are then compared arithmetically against that model.

// File: rtl/map_pkg.sv
package map_pkg;
  // byte lane within one 4-byte entry slot
  typedef enum logic [1:0] {
    LANE_LO0 = 2'd0,
    LANE_LO1 = 2'd1,
    LANE_HI0 = 2'd2,
    LANE_HI1 = 2'd3
  } lane_e;

  localparam int unsigned SLOT_W = 32;  // register bits spanned per entry
endpackage

// File: rtl/map_reg_merge.sv
module map_reg_merge #(
  parameter int unsigned ENT_W = 22,
  parameter int unsigned DAT_W = 16
) (
  input  logic [ENT_W-1:0] old_ent,
  input  logic [1:0]       sel,
  input  logic             is_byte,
  input  logic [DAT_W-1:0] wdata,
  output logic [ENT_W-1:0] new_ent
);
  import map_pkg::*;

  localparam int unsigned PAD_W = SLOT_W - ENT_W;

  logic [SLOT_W-1:0] slot;
  lane_e             lane;

  assign lane = lane_e'(sel);

  always_comb begin
    slot = {{PAD_W{1'b0}}, old_ent};
    if (is_byte) begin
      unique case (lane)
        LANE_LO0: slot[7:0]   = wdata[7:0];
        LANE_LO1: slot[15:8]  = wdata[7:0];
        LANE_HI0: slot[23:16] = wdata[7:0];
        LANE_HI1: slot[31:24] = wdata[7:0];
        default:  slot        = slot;
      endcase
    end else if (sel[1]) begin
      slot[31:16] = wdata;
    end else begin
      slot[15:0] = wdata;
    end
    new_ent = {slot[ENT_W-1:1], 1'b0};
  end
endmodule

// File: rtl/map_entry_file.sv
module map_entry_file #(
  parameter int unsigned ENT_W  = 22,
  parameter int unsigned DAT_W  = 16,
  parameter int unsigned PG_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_byte,
  input  logic [PG_W+1:0]   reg_addr,
  input  logic [DAT_W-1:0]  reg_wdata,
  output logic [DAT_W-1:0]  reg_rdata,
  input  logic [PG_W-1:0]   xl_page,
  output logic [ENT_W-1:0]  xl_entry
);
  localparam int unsigned NUM_ENT = 1 << PG_W;
  localparam int unsigned HI_W    = ENT_W - DAT_W;

  logic [ENT_W-1:0] ent_q [NUM_ENT];
  logic [PG_W-1:0]  wr_idx;
  logic [ENT_W-1:0] merged;
  logic [ENT_W-1:0] rd_ent;

  assign wr_idx   = reg_addr[PG_W+1:2];
  assign rd_ent   = ent_q[wr_idx];
  assign xl_entry = ent_q[xl_page];

  map_reg_merge #(.ENT_W(ENT_W), .DAT_W(DAT_W)) merge_i (
    .old_ent (rd_ent),
    .sel     (reg_addr[1:0]),
    .is_byte (reg_byte),
    .wdata   (reg_wdata),
    .new_ent (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENT; i++) ent_q[i] <= '0;
    end else if (reg_we) begin
      ent_q[wr_idx] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_addr[1]) reg_rdata <= {{(DAT_W-HI_W){1'b0}}, rd_ent[ENT_W-1:DAT_W]};
    else reg_rdata <= {rd_ent[DAT_W-1:1], 1'b0};
  end

  // word write into the low half lands with bit 0 cleared
  p_word_lo_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !reg_byte && !reg_addr[1]) |=>
      ent_q[$past(wr_idx)][DAT_W-1:0] == {$past(reg_wdata[DAT_W-1:1]), 1'b0});

  // a lane 3 byte write must not alter the entry
  p_lane3_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_byte && reg_addr[1:0] == 2'd3) |=>
      ent_q[$past(wr_idx)] == $past(rd_ent));

  // upper-half reads carry only the high entry bits
  p_hi_read_r3: assert property (@(posedge clk) disable iff (rst)
    reg_addr[1] |=> reg_rdata[DAT_W-1:HI_W] == '0);
endmodule

// File: rtl/map_xlate_path.sv
module map_xlate_path #(
  parameter int unsigned BUS_AW  = 18,
  parameter int unsigned PHYS_AW = 22,
  parameter int unsigned OFF_W   = 13,
  parameter logic [PHYS_AW-1:0] IO_BASE = 22'o17760000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BUS_AW-1:0]  xl_addr,
  input  logic               map_en,
  input  logic [PHYS_AW-1:0] mem_size,
  input  logic [PHYS_AW-1:0] xl_entry,
  output logic [PHYS_AW-1:0] xl_paddr,
  output logic               xl_nxm
);
  localparam int unsigned PG_W = BUS_AW - OFF_W;

  logic [PG_W-1:0]    page;
  logic [PHYS_AW-1:0] off_ext;
  logic [PHYS_AW-1:0] base;
  logic [PHYS_AW-1:0] phys_d;

  assign page    = xl_addr[BUS_AW-1:OFF_W];
  assign off_ext = {{(PHYS_AW-OFF_W){1'b0}}, xl_addr[OFF_W-1:0]};

  always_comb begin
    base = (&page) ? IO_BASE : xl_entry;
    if (map_en) phys_d = base + off_ext;
    else        phys_d = {{(PHYS_AW-BUS_AW){1'b0}}, xl_addr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xl_paddr <= '0;
      xl_nxm   <= 1'b0;
    end else begin
      xl_paddr <= phys_d;
      xl_nxm   <= (phys_d >= mem_size);
    end
  end

  p_io_page_r7: assert property (@(posedge clk) disable iff (rst)
    (map_en && (&page)) |=> xl_paddr == IO_BASE + $past(off_ext));

  p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
    !map_en |=> xl_paddr == {{(PHYS_AW-BUS_AW){1'b0}}, $past(xl_addr)});

  p_nxm_flag_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> xl_nxm == (xl_paddr >= $past(mem_size)));
endmodule

// File: rtl/bus_map_xlate.sv
module bus_map_xlate #(
  parameter int unsigned BUS_AW  = 18,
  parameter int unsigned PHYS_AW = 22,
  parameter int unsigned OFF_W   = 13,
  parameter int unsigned DAT_W   = 16,
  parameter logic [PHYS_AW-1:0] IO_BASE = 22'o17760000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic               reg_byte,
  input  logic [BUS_AW-OFF_W+1:0] reg_addr,
  input  logic [DAT_W-1:0]   reg_wdata,
  output logic [DAT_W-1:0]   reg_rdata,
  input  logic [BUS_AW-1:0]  xl_addr,
  input  logic               map_en,
  input  logic [PHYS_AW-1:0] mem_size,
  output logic [PHYS_AW-1:0] xl_paddr,
  output logic               xl_nxm
);
  localparam int unsigned PG_W = BUS_AW - OFF_W;

  logic [PHYS_AW-1:0] entry_w;

  map_entry_file #(.ENT_W(PHYS_AW), .DAT_W(DAT_W), .PG_W(PG_W)) file_i (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_byte  (reg_byte),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .xl_page   (xl_addr[BUS_AW-1:OFF_W]),
    .xl_entry  (entry_w)
  );

  map_xlate_path #(.BUS_AW(BUS_AW), .PHYS_AW(PHYS_AW), .OFF_W(OFF_W),
                   .IO_BASE(IO_BASE)) path_i (
    .clk      (clk),
    .rst      (rst),
    .xl_addr  (xl_addr),
    .map_en   (map_en),
    .mem_size (mem_size),
    .xl_entry (entry_w),
    .xl_paddr (xl_paddr),
    .xl_nxm   (xl_nxm)
  );

  // a same-cycle write must not leak into the translation of that cycle (R10)
  p_old_entry_r10: assert property (@(posedge clk) disable iff (rst)
    (map_en && !(&xl_addr[BUS_AW-1:OFF_W])) |=>
      xl_paddr == $past(entry_w) + {{(PHYS_AW-OFF_W){1'b0}}, $past(xl_addr[OFF_W-1:0])});
endmodule

// File: tb/bus_map_xlate_tb_top.sv
module bus_map_xlate_tb_top;
  localparam logic [21:0] IOB = 22'o17760000;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we, reg_byte, map_en;
  logic [6:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [17:0] xl_addr;
  logic [21:0] mem_size, xl_paddr;
  logic        xl_nxm;

  int n_chk = 0;
  int n_bad = 0;
  logic [21:0] mdl [32];

  always #4 clk = ~clk;

  bus_map_xlate dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_byte(reg_byte),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xl_addr(xl_addr), .map_en(map_en), .mem_size(mem_size),
    .xl_paddr(xl_paddr), .xl_nxm(xl_nxm)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] mdl_merge(input logic [21:0] old, input logic [1:0] a,
                                            input logic [15:0] wd, input logic byt);
    logic [31:0] w;
    w = {10'b0, old};
    if (byt) begin
      case (a)
        2'd0: w[7:0]   = wd[7:0];
        2'd1: w[15:8]  = wd[7:0];
        2'd2: w[23:16] = wd[7:0];
        default: w[31:24] = wd[7:0];
      endcase
    end else if (a[1]) w[31:16] = wd;
    else w[15:0] = wd;
    return {w[21:1], 1'b0};
  endfunction

  function automatic logic [21:0] exp_pa(input logic [17:0] a, input logic en);
    if (!en) return {4'b0, a};
    if (a[17:13] == 5'h1f) return IOB + {9'b0, a[12:0]};
    return mdl[a[17:13]] + {9'b0, a[12:0]};
  endfunction

  task automatic wr(input logic [4:0] e, input logic [1:0] sel, input logic [15:0] d,
                    input logic byt);
    reg_we = 1'b1; reg_byte = byt; reg_addr = {e, sel}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    mdl[e] = mdl_merge(mdl[e], sel, d, byt);
  endtask

  task automatic rd(input logic [4:0] e, input string req);
    reg_addr = {e, 2'b00};
    @(negedge clk);
    check(req, {16'b0, reg_rdata}, {16'b0, mdl[e][15:1], 1'b0});
    reg_addr = {e, 2'b10};
    @(negedge clk);
    check(req, {16'b0, reg_rdata}, {26'b0, mdl[e][21:16]});
  endtask

  task automatic xl(input logic [17:0] a, input logic en, input logic [21:0] ms,
                    input string req);
    logic [21:0] e;
    xl_addr = a; map_en = en; mem_size = ms;
    e = exp_pa(a, en);
    @(negedge clk);
    check(req, {10'b0, xl_paddr}, {10'b0, e});
    check("R9", {31'b0, xl_nxm}, {31'b0, (e >= ms)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [21:0] old5;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    rst = 1'b1; reg_we = 1'b0; reg_byte = 1'b0; reg_addr = '0; reg_wdata = '0;
    xl_addr = '0; map_en = 1'b0; mem_size = 22'h3FFFFF;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", {10'b0, xl_paddr}, 32'h0);
    check("R1", {31'b0, xl_nxm}, 32'h0);
    check("R1", {16'b0, reg_rdata}, 32'h0);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) rd(5'(i), "R1");

    // R2/R3/R5: word writes to every entry, odd low data, oversized high data
    for (int i = 0; i < 32; i++) begin
      wr(5'(i), 2'b00, (16'(i) * 16'h1357) ^ 16'hA5A5 | 16'h0001, 1'b0);
      wr(5'(i), 2'b10, 16'hFFC0 | 16'(i * 7), 1'b0);
    end
    for (int i = 0; i < 32; i++) rd(5'(i), "R2_R3_R5");

    // R4: byte lanes on entry 9
    wr(5'd9, 2'b00, 16'h0000, 1'b0);
    wr(5'd9, 2'b10, 16'h0000, 1'b0);
    wr(5'd9, 2'd0, 16'h77FF, 1'b1); rd(5'd9, "R4");
    check("R4", {10'b0, mdl[9]}, 32'h0000FE);
    wr(5'd9, 2'd1, 16'h11C3, 1'b1); rd(5'd9, "R4");
    wr(5'd9, 2'd2, 16'h22FF, 1'b1); rd(5'd9, "R4");
    wr(5'd9, 2'd3, 16'hFFFF, 1'b1); rd(5'd9, "R4");
    check("R4", {10'b0, mdl[9]}, 32'h3FC3FE);

    // R6: every page, boundary offsets
    for (int p = 0; p < 31; p++) begin
      xl({5'(p), 13'h0000}, 1'b1, 22'h200000, "R6");
      xl({5'(p), 13'h0001}, 1'b1, 22'h200000, "R6");
      xl({5'(p), 13'h1000}, 1'b1, 22'h200000, "R6");
      xl({5'(p), 13'h1FFF}, 1'b1, 22'h200000, "R6");
    end
    // R6: carry out of bit 21 wraps
    wr(5'd3, 2'b00, 16'hFFFF, 1'b0);
    wr(5'd3, 2'b10, 16'h003F, 1'b0);
    xl({5'd3, 13'h1FFF}, 1'b1, 22'h3FFFFF, "R6");
    check("R6", {10'b0, xl_paddr}, 32'h001FFD);

    // R7: top page ignores entry 31
    wr(5'd31, 2'b00, 16'h1234, 1'b0);
    xl({5'h1f, 13'h0000}, 1'b1, 22'h3FFFFF, "R7");
    check("R7", {10'b0, xl_paddr}, {10'b0, IOB});
    xl({5'h1f, 13'h1FFF}, 1'b1, 22'h3FFFFF, "R7");
    xl({5'h1f, 13'h0ABC}, 1'b1, 22'h000000, "R7");

    // R8: unmapped sweep
    for (int a = 0; a < 18'h40000; a += 18'h0137B) xl(18'(a), 1'b0, 22'h020000, "R8");
    xl(18'h3FFFF, 1'b0, 22'h3FFFFF, "R8");

    // R9: boundary around the result
    xl(18'h12345, 1'b0, 22'h012345, "R9");
    check("R9", {31'b0, xl_nxm}, 32'h1);
    xl(18'h12345, 1'b0, 22'h012346, "R9");
    check("R9", {31'b0, xl_nxm}, 32'h0);
    xl({5'd4, 13'h0010}, 1'b1, mdl[4] + 22'h10, "R9");
    xl({5'd4, 13'h0010}, 1'b1, mdl[4] + 22'h11, "R9");

    // R10: write and translate the same entry in one cycle
    old5 = mdl[5];
    xl_addr = {5'd5, 13'h0040}; map_en = 1'b1; mem_size = 22'h3FFFFF;
    reg_we = 1'b1; reg_byte = 1'b0; reg_addr = {5'd5, 2'b00}; reg_wdata = 16'h8000;
    @(negedge clk);
    reg_we = 1'b0;
    mdl[5] = mdl_merge(mdl[5], 2'b00, 16'h8000, 1'b0);
    check("R10", {10'b0, xl_paddr}, {10'b0, old5 + 22'h40});
    @(negedge clk);
    check("R10", {10'b0, xl_paddr}, {10'b0, mdl[5] + 22'h40});

    // R1: reset again clears entries
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    rd(5'd5, "R1");
    rd(5'd9, "R1");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule